// File: doc/BRIEF.md
# GPIO Pin Interrupt Front End

This block turns a bank of general-purpose input pins into interrupt requests for a parent interrupt controller. Every pin is brought into the clock domain through a two-flop synchroniser. A per-pin polarity bit then inverts the line or leaves it as is, and the result is the pin's data-in value. A pin can raise a request in two ways. As a level source, its data-in bit is gated by a level mask with no memory, so the request follows the line. As an edge source, a qualifying transition sets a sticky bit in an edge cause register, and an edge mask gates that bit.

The two contributions of a pin are ORed into a per-pin cause. The per-pin causes are then ORed in groups of eight, giving one request output for each group. Software works through a simple register bus. A read issued in one cycle returns its data in the next cycle. A write takes effect at the clock edge that samples it. To detect both edges, software flips the pin's polarity bit each time it services an edge, which arms the detector for the opposite transition.

An edge is recorded only when the synchronised raw line has changed and the new post-polarity value is 1. Changing a polarity bit while the line is steady therefore records nothing.

Top module: `pinirq_top`

## Requirements
- R1: After reset, the polarity, edge mask, level mask and edge cause registers all read 0, and every group output is 0.
- R2: A read of offset 0x00 returns data-in, which is the synchronised pin value XOR the polarity register. A pin change shows up in data-in after two clock edges.
- R3: The polarity register at offset 0x04 can be written and read back. A 1 in a bit inverts that pin's line.
- R4: A pin's level contribution is its data-in bit AND its level mask bit (offset 0x10). There is no latching: the request drops as soon as data-in returns to 0.
- R5: An edge cause bit (offset 0x08) is set when the synchronised raw line changes and the new data-in bit is 1. The bit then stays set until software clears it.
- R6: Changing a polarity bit while the pin is steady sets no edge cause bit.
- R7: A write to offset 0x08 clears every cause bit written as 0 and leaves every bit written as 1 unchanged. If an edge arrives in the same cycle as the clear, the bit ends up set.
- R8: A pin's edge contribution is its cause bit AND its edge mask bit (offset 0x0C). With both masks at 0, no group output is asserted.
- R9: Group output g is the OR of the per-pin causes of pins 8g to 8g+7. A per-pin cause is the level contribution OR the edge contribution.
- R10: Read data appears on the cycle after the read request and holds until the next read. Reads of unmapped offsets return 0. Writes to offset 0x00 change no register.
- R11: To detect both edges, software toggles the polarity bit: with polarity 1 a falling line sets the cause bit, and with polarity 0 a rising line sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw, unsynchronised pin levels |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data, valid the cycle after a read |
| group_irq | output | NPINS/8 | One interrupt request for each group of eight pins |

## Verification
The bench aims a cause-register clear at the exact cycle in which an edge becomes visible. A design in which the clear wins would lose that edge, and the pin's cause bit would read back 0 instead of 1. It flips polarity on steady lines, once alone and once as the first step of a both-edge sequence. A detector built on post-polarity data-in alone would invent edges there, and group outputs would rise with no pin activity. It drops a level-masked line and expects the group output to fall at once, which exposes any latching on the level path. It also checks that group outputs map to the right eight pins, that unmapped offsets read 0, and that writes to the read-only data-in offset touch nothing.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DIN   = 5'h00,
    OFF_POL   = 5'h04,
    OFF_CAUSE = 5'h08,
    OFF_EMASK = 5'h0C,
    OFF_LMASK = 5'h10
  } reg_off_e;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_sync,
  input  logic [W-1:0] pol,
  output logic [W-1:0] data_in,
  output logic [W-1:0] edge_hit
);
  // Previous raw synchronised level: edges are judged on the raw line so a
  // polarity change alone never counts as a transition.
  logic [W-1:0] line_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_prev_q <= '0;
    else        line_prev_q <= line_sync;
  end

  assign data_in  = line_sync ^ pol;
  assign edge_hit = (line_sync ^ line_prev_q) & data_in;
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
  import pinirq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      data_in,
  input  logic [W-1:0]      edge_hit,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      emask_q,
  output logic [W-1:0]      lmask_q,
  output logic [W-1:0]      cause_q
);
  logic         wr_en;
  logic         rd_en;
  logic [W-1:0] cause_keep;
  logic [W-1:0] rd_mux;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_comb begin
    cause_keep = '1;
    if (wr_en && bus_addr == OFF_CAUSE) cause_keep = bus_wdata;
  end

  always_comb begin
    case (bus_addr)
      OFF_DIN:   rd_mux = data_in;
      OFF_POL:   rd_mux = pol_q;
      OFF_CAUSE: rd_mux = cause_q;
      OFF_EMASK: rd_mux = emask_q;
      OFF_LMASK: rd_mux = lmask_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q     <= '0;
      emask_q   <= '0;
      lmask_q   <= '0;
      cause_q   <= '0;
      bus_rdata <= '0;
    end else begin
      // new edges override a clear in the same cycle
      cause_q <= (cause_q & cause_keep) | edge_hit;
      if (wr_en && bus_addr == OFF_POL)   pol_q   <= bus_wdata;
      if (wr_en && bus_addr == OFF_EMASK) emask_q <= bus_wdata;
      if (wr_en && bus_addr == OFF_LMASK) lmask_q <= bus_wdata;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pinirq_group.sv
module pinirq_group #(
  parameter int unsigned W  = 32,
  parameter int unsigned GW = 8,
  localparam int unsigned NG = W / GW
) (
  input  logic [W-1:0]  data_in,
  input  logic [W-1:0]  lmask,
  input  logic [W-1:0]  cause,
  input  logic [W-1:0]  emask,
  output logic [NG-1:0] group_irq
);
  logic [W-1:0] pin_cause;

  assign pin_cause = (data_in & lmask) | (cause & emask);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign group_irq[g] = |pin_cause[g*GW +: GW];
  end
endmodule

// File: rtl/pinirq_top.sv
module pinirq_top
  import pinirq_pkg::*;
#(
  parameter int unsigned NPINS   = 32,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned NGROUPS = NPINS / GROUP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NPINS-1:0]   bus_wdata,
  output logic [NPINS-1:0]   bus_rdata,
  output logic [NGROUPS-1:0] group_irq
);
  logic [NPINS-1:0] line_sync;
  logic [NPINS-1:0] data_in;
  logic [NPINS-1:0] edge_hit;
  logic [NPINS-1:0] pol_q;
  logic [NPINS-1:0] emask_q;
  logic [NPINS-1:0] lmask_q;
  logic [NPINS-1:0] cause_q;

  pinirq_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(line_sync)
  );

  pinirq_detect #(.W(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .pol(pol_q),
    .data_in(data_in), .edge_hit(edge_hit)
  );

  pinirq_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .data_in(data_in), .edge_hit(edge_hit),
    .pol_q(pol_q), .emask_q(emask_q), .lmask_q(lmask_q), .cause_q(cause_q)
  );

  pinirq_group #(.W(NPINS), .GW(GROUP_W)) u_group (
    .data_in(data_in), .lmask(lmask_q), .cause(cause_q), .emask(emask_q),
    .group_irq(group_irq)
  );
endmodule

// File: rtl/pinirq_checker.sv
module pinirq_checker
  import pinirq_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned NG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NG-1:0]     group_irq,
  input logic [W-1:0]      edge_hit,
  input logic [W-1:0]      pol_q,
  input logic [W-1:0]      emask_q,
  input logic [W-1:0]      lmask_q,
  input logic [W-1:0]      cause_q
);
  logic cause_wr;
  logic din_wr;
  assign cause_wr = bus_sel && bus_wr && bus_addr == OFF_CAUSE;
  assign din_wr   = bus_sel && bus_wr && bus_addr == OFF_DIN;

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (group_irq == '0));

  assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit == '0) |=> ((cause_q & ~$past(cause_q)) == '0));

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((cause_q & $past(edge_hit)) == $past(edge_hit)));

  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (emask_q == '0 && lmask_q == '0) |-> (group_irq == '0));

  assert_din_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    din_wr |=> ($stable(pol_q) && $stable(emask_q) && $stable(lmask_q)));
endmodule

bind pinirq_top pinirq_checker #(.W(NPINS), .NG(NGROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .group_irq(group_irq), .edge_hit(edge_hit),
  .pol_q(pol_q), .emask_q(emask_q), .lmask_q(lmask_q), .cause_q(cause_q)
);

// File: tb/test_pinirq_top.sv
`timescale 1ns/1ps
module test_pinirq_top;
  localparam int NP = 32;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_in;
  logic          bus_sel;
  logic          bus_wr;
  logic [4:0]    bus_addr;
  logic [NP-1:0] bus_wdata;
  logic [NP-1:0] bus_rdata;
  logic [NG-1:0] group_irq;

  int  n_checks = 0;
  int  n_err    = 0;
  bit  done     = 1'b0;

  always #2.5 clk = ~clk;

  pinirq_top i_pinirq_top (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .group_irq(group_irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_s1, m_s2, m_prev, m_pol, m_cause, m_em, m_lm, m_rd;
  logic [31:0] t_din, t_hit, t_keep;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pol = '0;
      m_cause = '0; m_em = '0; m_lm = '0; m_rd = '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        t_din[i] = m_s2[i] ^ m_pol[i];
        t_hit[i] = (m_s2[i] != m_prev[i]) && t_din[i];
      end
      if (bus_sel && !bus_wr) begin
        case (int'(bus_addr))
          0:  m_rd = t_din;
          4:  m_rd = m_pol;
          8:  m_rd = m_cause;
          12: m_rd = m_em;
          16: m_rd = m_lm;
          default: m_rd = '0;
        endcase
      end
      t_keep = (bus_sel && bus_wr && int'(bus_addr) == 8) ? bus_wdata : 32'hFFFF_FFFF;
      m_cause = (m_cause & t_keep) | t_hit;
      if (bus_sel && bus_wr && int'(bus_addr) == 4)  m_pol = bus_wdata;
      if (bus_sel && bus_wr && int'(bus_addr) == 12) m_em  = bus_wdata;
      if (bus_sel && bus_wr && int'(bus_addr) == 16) m_lm  = bus_wdata;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_in;
    end
  end

  function automatic logic [NG-1:0] model_irq();
    logic [NG-1:0] r = '0;
    for (int g = 0; g < NG; g++)
      for (int i = g*8; i < g*8 + 8; i++)
        if ((((m_s2[i] ^ m_pol[i]) & m_lm[i]) | (m_cause[i] & m_em[i])) == 1'b1)
          r[g] = 1'b1;
    return r;
  endfunction

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check(group_irq === model_irq(), "R9 group outputs vs model",
            32'(group_irq), 32'(model_irq()));
      check(bus_rdata === m_rd, "R10 read data vs model", bus_rdata, m_rd);
    end
  end

  // ---------------- bus helpers ----------------
  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] rd;

  initial begin
    rst_n = 1'b0; pin_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    check(group_irq === 4'b0000, "R1 group outputs after reset", 32'(group_irq), 0);
    bus_read(5'h08, rd); check(rd === 0, "R1 cause after reset", rd, 0);
    bus_read(5'h0C, rd); check(rd === 0, "R1 edge mask after reset", rd, 0);
    bus_read(5'h10, rd); check(rd === 0, "R1 level mask after reset", rd, 0);
    bus_read(5'h04, rd); check(rd === 0, "R1 polarity after reset", rd, 0);

    // R3 / R2 / R6: invert steady-low lines
    bus_write(5'h04, 32'h0000_00F0);
    bus_read(5'h04, rd); check(rd === 32'h0000_00F0, "R3 polarity readback", rd, 32'h0000_00F0);
    bus_read(5'h00, rd); check(rd === 32'h0000_00F0, "R2 inverted data-in", rd, 32'h0000_00F0);
    bus_write(5'h04, 32'h0);
    wait_cyc(3);
    bus_read(5'h08, rd); check(rd === 0, "R6 polarity toggle sets nothing", rd, 0);

    // R2 / R5: rising lines
    pin_in = 32'hA5A5_0003;
    wait_cyc(3);
    bus_read(5'h00, rd); check(rd === 32'hA5A5_0003, "R2 data-in follows pins", rd, 32'hA5A5_0003);
    bus_read(5'h08, rd); check(rd === 32'hA5A5_0003, "R5 cause latched on rise", rd, 32'hA5A5_0003);
    check(group_irq === 4'b0000, "R8 masks zero keep outputs low", 32'(group_irq), 0);

    // R8 / R9: edge mask on pin 16 -> group 2
    bus_write(5'h0C, 32'h0001_0000);
    check(group_irq === 4'b0100, "R9 pin 16 drives group 2", 32'(group_irq), 4);
    bus_write(5'h08, 32'hFFFE_FFFF);
    check(group_irq === 4'b0000, "R8 cleared cause drops output", 32'(group_irq), 0);
    bus_read(5'h08, rd); check(rd === 32'hA5A4_0003, "R7 write-zero clears only that bit", rd, 32'hA5A4_0003);

    // R4 level path, no latching
    bus_write(5'h10, 32'h8000_0000);
    check(group_irq === 4'b1000, "R4 level on pin 31", 32'(group_irq), 8);
    pin_in = 32'h25A5_0003;
    wait_cyc(3);
    check(group_irq === 4'b0000, "R4 level drops with line", 32'(group_irq), 0);
    bus_read(5'h08, rd); check(rd === 32'hA5A4_0003, "R5 falling line sets no cause", rd, 32'hA5A4_0003);
    bus_write(5'h10, 32'h0);

    // R11 both-edge via polarity flip on pin 0 (currently high)
    bus_write(5'h08, 32'h0);
    bus_write(5'h0C, 32'h0000_0001);
    bus_write(5'h04, 32'h0000_0001);
    wait_cyc(3);
    bus_read(5'h08, rd); check(rd === 0, "R6 polarity flip on high line", rd, 0);
    pin_in = 32'h25A5_0002;
    wait_cyc(4);
    check(group_irq === 4'b0001, "R11 falling edge with polarity 1", 32'(group_irq), 1);
    bus_write(5'h08, 32'h0);
    bus_write(5'h04, 32'h0);
    wait_cyc(2);
    check(group_irq === 4'b0000, "R11 rearmed, no event yet", 32'(group_irq), 0);
    pin_in = 32'h25A5_0003;
    wait_cyc(4);
    check(group_irq === 4'b0001, "R11 rising edge with polarity 0", 32'(group_irq), 1);

    // R7 edge in the same cycle as a full clear
    bus_write(5'h08, 32'h0);
    bus_write(5'h0C, 32'h0);
    pin_in = 32'h25A5_0023;
    wait_cyc(2);
    bus_write(5'h08, 32'h0);
    bus_read(5'h08, rd); check(rd === 32'h0000_0020, "R7 set wins over clear", rd, 32'h20);

    // R10 unmapped read, data-in write ignored
    bus_read(5'h14, rd); check(rd === 0, "R10 unmapped offset reads zero", rd, 0);
    bus_write(5'h04, 32'h0000_1111);
    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_read(5'h04, rd); check(rd === 32'h0000_1111, "R10 data-in write leaves polarity", rd, 32'h1111);
    bus_read(5'h0C, rd); check(rd === 0, "R10 data-in write leaves edge mask", rd, 0);
    bus_read(5'h10, rd); check(rd === 0, "R10 data-in write leaves level mask", rd, 0);
    wait_cyc(2);
    check(bus_rdata === 0, "R10 read data holds between reads", bus_rdata, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end
endmodule